// File: doc/BRIEF.md
# Multi-CPU Masked Interrupt Aggregator

This block gathers a vector of level-sensitive device interrupt lines into one shared raw request register and hands a filtered copy of it to each of several CPUs. Every CPU slot owns a full-width mask register. The slot's hard-interrupt output is raised whenever the AND of its mask and the raw register is nonzero. A separate input from a legacy cascaded interrupt controller replaces one fixed request bit. A per-slot present input silences slots that hold no CPU.

Software reaches the block through a register port built as a request/response stream. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Exactly one response follows on the next cycle. That response stays on `rsp_valid`, `rsp_rdata` and `rsp_error` until the cycle in which `rsp_ready` is high. While a response waits, `req_ready` is low, so the requester is held back by the response consumer. Accepted accesses read or write from the register state as it stood before the accepting edge.

Top module: `irq_aggregator`

## Requirements
- R1: Raw request bit i follows `dev_lines[i]` one clock later and holds no memory: it clears one clock after the line drops. Reading offset 0x300 returns the raw register.
- R2: Raw bit 55 is taken from `legacy_irq` alone; `dev_lines[55]` has no effect on the raw register or on any output.
- R3: Reading the masked view of CPU n returns the AND of mask n and the raw register. The view offsets are 0x280, 0x2C0, 0x680 and 0x6C0 for CPU0 to CPU3.
- R4: `cpu_irq[n]` is high exactly when `cpu_present[n]` is high and mask n AND raw is nonzero. The output follows a raw change or a mask write in the cycle after the edge that caused it, including when both land on the same edge.
- R5: After reset all masks read zero, every `cpu_irq` bit is low and no response is pending.
- R6: The mask registers for CPU0 to CPU3 sit at 0x200, 0x240, 0x600 and 0x640. Each is read and written as a whole 64-bit word.
- R7: A full-width write to the raw offset or to a masked view offset returns a response with `rsp_error` low and changes no state.
- R8: An access whose `req_wstrb` is not all ones returns `rsp_error` high with data zero and changes no state.
- R9: An access to any offset not listed in R1, R3 or R6 returns `rsp_error` high with data zero and changes no state.
- R10: A slot whose `cpu_present` bit is low never drives its `cpu_irq` bit high.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the response holds stable and `req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_lines | input | 64 | Level device interrupt lines |
| legacy_irq | input | 1 | Legacy cascaded controller request, drives raw bit 55 |
| cpu_present | input | 4 | One bit per CPU slot, high when the slot is populated |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted this cycle when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register byte offset |
| req_wdata | input | 64 | Write data |
| req_wstrb | input | 8 | Byte enables; must be all ones |
| rsp_valid | output | 1 | Response pending |
| rsp_ready | input | 1 | Response consumed this cycle when high with valid |
| rsp_rdata | output | 64 | Read data, zero for writes and errors |
| rsp_error | output | 1 | Access rejected |
| cpu_irq | output | 4 | Hard-interrupt request per CPU |

## Verification
A mask write and a change of the device lines can both land on the same clock edge. The outputs must then reflect the new mask combined with the new raw value, and the read view must reflect neither. The bench provokes this by changing the lines in the same cycle that a mask write is accepted. It judges the result both against a behavioural model that updates mask and raw together on every edge and against a directed check on the affected CPU output one cycle later.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] RAW_OFFSET = 12'h300;

  // CPU pairs share a 0x400-spaced bank; the view sits 0x80 above the mask
  function automatic logic [ADDR_W-1:0] mask_offset(input int unsigned cpu);
    return 12'h200 + 12'(cpu / 2) * 12'h400 + 12'(cpu % 2) * 12'h040;
  endfunction

  function automatic logic [ADDR_W-1:0] view_offset(input int unsigned cpu);
    return mask_offset(cpu) + 12'h080;
  endfunction
endpackage

// File: rtl/irq_raw_capture.sv
module irq_raw_capture #(
  parameter int NUM_LINES  = 64,
  parameter int LEGACY_BIT = 55
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] dev_lines,
  input  logic                 legacy_irq,
  output logic [NUM_LINES-1:0] raw_q
);
  logic [NUM_LINES-1:0] raw_next;

  always_comb begin
    raw_next = dev_lines;
    raw_next[LEGACY_BIT] = legacy_irq;
  end

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= raw_next;
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int NUM_CPUS = 4,
  parameter int WIDTH    = 64
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_CPUS-1:0]             wr_en,
  input  logic [WIDTH-1:0]                wr_data,
  input  logic [WIDTH-1:0]                raw,
  input  logic [NUM_CPUS-1:0]             present,
  output logic [NUM_CPUS-1:0][WIDTH-1:0]  mask_q,
  output logic [NUM_CPUS-1:0][WIDTH-1:0]  masked,
  output logic [NUM_CPUS-1:0]             irq
);
  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (rst)          mask_q[c] <= '0;
      else if (wr_en[c]) mask_q[c] <= wr_data;
    end
    assign masked[c] = mask_q[c] & raw;
    assign irq[c]    = present[c] & (|masked[c]);
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_agg_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int WIDTH    = 64,
  localparam int STRB_W  = WIDTH / 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_write,
  input  logic [ADDR_W-1:0]               req_addr,
  input  logic [STRB_W-1:0]               req_wstrb,
  output logic                            rsp_valid,
  input  logic                            rsp_ready,
  output logic [WIDTH-1:0]                rsp_rdata,
  output logic                            rsp_error,
  input  logic [NUM_CPUS-1:0][WIDTH-1:0]  mask_q,
  input  logic [NUM_CPUS-1:0][WIDTH-1:0]  masked,
  input  logic [WIDTH-1:0]                raw,
  output logic [NUM_CPUS-1:0]             mask_we
);
  logic [NUM_CPUS-1:0] hit_mask, hit_view;
  logic                hit_raw, known, full, legal, accept;
  logic [WIDTH-1:0]    sel_data;

  always_comb begin
    hit_mask = '0;
    hit_view = '0;
    sel_data = '0;
    for (int i = 0; i < NUM_CPUS; i++) begin
      hit_mask[i] = (req_addr == mask_offset(i));
      hit_view[i] = (req_addr == view_offset(i));
      if (hit_mask[i]) sel_data = sel_data | mask_q[i];
      if (hit_view[i]) sel_data = sel_data | masked[i];
    end
    hit_raw = (req_addr == RAW_OFFSET);
    if (hit_raw) sel_data = sel_data | raw;
  end

  assign known     = hit_raw | (|hit_mask) | (|hit_view);
  assign full      = &req_wstrb;
  assign legal     = known & full;
  assign req_ready = ~rsp_valid;
  assign accept    = req_valid & req_ready;
  assign mask_we   = {NUM_CPUS{accept & req_write & legal}} & hit_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_error <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_error <= ~legal;
      rsp_rdata <= (legal && !req_write) ? sel_data : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_LINES  = 64,
  parameter int NUM_CPUS   = 4,
  parameter int LEGACY_BIT = 55,
  localparam int STRB_W    = NUM_LINES / 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] dev_lines,
  input  logic                 legacy_irq,
  input  logic [NUM_CPUS-1:0]  cpu_present,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [NUM_LINES-1:0] req_wdata,
  input  logic [STRB_W-1:0]    req_wstrb,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [NUM_LINES-1:0] rsp_rdata,
  output logic                 rsp_error,
  output logic [NUM_CPUS-1:0]  cpu_irq
);
  logic [NUM_LINES-1:0]                raw_q;
  logic [NUM_CPUS-1:0][NUM_LINES-1:0]  mask_q, masked;
  logic [NUM_CPUS-1:0]                 mask_we;

  irq_raw_capture #(.NUM_LINES(NUM_LINES), .LEGACY_BIT(LEGACY_BIT)) u_raw (
    .clk(clk), .rst(rst), .dev_lines(dev_lines), .legacy_irq(legacy_irq),
    .raw_q(raw_q)
  );

  irq_mask_bank #(.NUM_CPUS(NUM_CPUS), .WIDTH(NUM_LINES)) u_bank (
    .clk(clk), .rst(rst), .wr_en(mask_we), .wr_data(req_wdata), .raw(raw_q),
    .present(cpu_present), .mask_q(mask_q), .masked(masked), .irq(cpu_irq)
  );

  irq_reg_port #(.NUM_CPUS(NUM_CPUS), .WIDTH(NUM_LINES)) u_port (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wstrb(req_wstrb),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_error(rsp_error), .mask_q(mask_q), .masked(masked), .raw(raw_q),
    .mask_we(mask_we)
  );
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
  parameter int NUM_LINES  = 64,
  parameter int NUM_CPUS   = 4,
  parameter int LEGACY_BIT = 55,
  localparam int STRB_W    = NUM_LINES / 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_LINES-1:0] dev_lines,
  input logic                 legacy_irq,
  input logic [NUM_CPUS-1:0]  cpu_present,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [STRB_W-1:0]    req_wstrb,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [NUM_LINES-1:0] rsp_rdata,
  input logic                 rsp_error,
  input logic [NUM_CPUS-1:0]  cpu_irq
);
  localparam logic [NUM_LINES-1:0] NOT_LEGACY = ~(NUM_LINES'(1) << LEGACY_BIT);

  a_r5_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rsp_valid && cpu_irq == '0));

  a_r10_absent_silent: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq & ~cpu_present) == '0);

  a_r4_no_request_no_irq: assert property (@(posedge clk) disable iff (rst)
    ((dev_lines & NOT_LEGACY) == '0 && !legacy_irq) |=> cpu_irq == '0);

  a_r11_hold_response: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_rdata) && $stable(rsp_error)));

  a_r11_no_accept_pending: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);

  a_r8_partial_rejected: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !(&req_wstrb)) |=>
      (rsp_valid && rsp_error && rsp_rdata == '0));
endmodule

bind irq_aggregator irq_agg_checker #(
  .NUM_LINES(NUM_LINES), .NUM_CPUS(NUM_CPUS), .LEGACY_BIT(LEGACY_BIT)
) u_chk (
  .clk(clk), .rst(rst), .dev_lines(dev_lines), .legacy_irq(legacy_irq),
  .cpu_present(cpu_present), .req_valid(req_valid), .req_ready(req_ready),
  .req_wstrb(req_wstrb), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .rsp_error(rsp_error), .cpu_irq(cpu_irq)
);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
  logic        clk = 0, rst = 1;
  logic [63:0] dev_lines = '0;
  logic        legacy_irq = 0;
  logic [3:0]  cpu_present = 4'hF;
  logic        req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [11:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_wstrb = 8'hFF;
  logic        req_ready, rsp_valid, rsp_error;
  logic [63:0] rsp_rdata;
  logic [3:0]  cpu_irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst(rst), .dev_lines(dev_lines), .legacy_irq(legacy_irq),
    .cpu_present(cpu_present), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wstrb(req_wstrb), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_error(rsp_error), .cpu_irq(cpu_irq)
  );

  // behavioural reference model
  logic [63:0] m_mask [4];
  logic [63:0] m_raw;
  logic        m_rv, m_re;
  logic [63:0] m_rd;

  function automatic int mask_idx(input logic [11:0] a);
    case (a)
      12'h200: return 0; 12'h240: return 1; 12'h600: return 2; 12'h640: return 3;
      default: return -1;
    endcase
  endfunction
  function automatic int view_idx(input logic [11:0] a);
    case (a)
      12'h280: return 0; 12'h2C0: return 1; 12'h680: return 2; 12'h6C0: return 3;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_mask[k]) m_mask[k] = '0;
      m_raw = '0; m_rv = 0; m_re = 0; m_rd = '0;
    end else begin
      if (req_valid && !m_rv) begin
        int mi, vi;
        bit ok;
        mi = mask_idx(req_addr);
        vi = view_idx(req_addr);
        ok = (req_wstrb == 8'hFF) && (mi >= 0 || vi >= 0 || req_addr == 12'h300);
        m_rv = 1; m_re = !ok; m_rd = '0;
        if (ok && !req_write) begin
          if (mi >= 0) m_rd = m_mask[mi];
          else if (vi >= 0) m_rd = m_mask[vi] & m_raw;
          else m_rd = m_raw;
        end
        if (ok && req_write && mi >= 0) m_mask[mi] = req_wdata;
      end else if (rsp_ready) m_rv = 0;
      m_raw = dev_lines;
      m_raw[55] = legacy_irq;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (!done) begin
      logic [3:0] eirq;
      for (int n = 0; n < 4; n++)
        eirq[n] = cpu_present[n] && ((m_mask[n] & m_raw) != '0);
      chk("R4 cpu_irq vs model", 64'(cpu_irq), 64'(eirq));
      chk("R11 req_ready vs model", 64'(req_ready), 64'(!m_rv));
      chk("R11 rsp_valid vs model", 64'(rsp_valid), 64'(m_rv));
      if (m_rv) begin
        chk("R9 rsp_error vs model", 64'(rsp_error), 64'(m_re));
        chk("R3 rsp_rdata vs model", rsp_rdata, m_rd);
      end
    end
  end

  task automatic access(input bit wr, input logic [11:0] a, input logic [63:0] d,
                        input logic [7:0] s, output logic [63:0] rd, output logic er);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_wstrb = s;
    @(negedge clk);
    req_valid = 0; req_wstrb = 8'hFF;
    rd = rsp_rdata; er = rsp_error;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    logic er;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R5 reset state
    chk("R5 cpu_irq after reset", 64'(cpu_irq), 0);
    chk("R5 rsp_valid after reset", 64'(rsp_valid), 0);
    access(0, 12'h640, 0, 8'hFF, rd, er);
    chk("R5 mask3 reset value", rd, 0);

    // R6 mask write / readback, R1 level following
    access(1, 12'h200, 64'h8, 8'hFF, rd, er);
    chk("R6 write mask0 error", 64'(er), 0);
    access(0, 12'h200, 0, 8'hFF, rd, er);
    chk("R6 read mask0", rd, 64'h8);
    @(negedge clk) dev_lines = 64'h8;
    @(negedge clk);
    chk("R4 irq0 raised by line 3", 64'(cpu_irq[0]), 1);
    access(0, 12'h300, 0, 8'hFF, rd, er);
    chk("R1 raw read", rd, 64'h8);
    access(0, 12'h280, 0, 8'hFF, rd, er);
    chk("R3 view cpu0", rd, 64'h8);
    dev_lines = '0;
    @(negedge clk);
    chk("R1 irq0 clears with line", 64'(cpu_irq[0]), 0);

    // R2 legacy bit
    access(1, 12'h240, 64'h0080_0000_0000_0000, 8'hFF, rd, er);
    dev_lines[55] = 1;
    @(negedge clk);
    chk("R2 device line 55 ignored irq1", 64'(cpu_irq[1]), 0);
    access(0, 12'h300, 0, 8'hFF, rd, er);
    chk("R2 device line 55 ignored raw", rd, 0);
    dev_lines[55] = 0; legacy_irq = 1;
    @(negedge clk);
    chk("R2 legacy raises irq1", 64'(cpu_irq[1]), 1);
    access(0, 12'h2C0, 0, 8'hFF, rd, er);
    chk("R3 view cpu1", rd, 64'h0080_0000_0000_0000);
    legacy_irq = 0;

    // R6 upper bank, R10 absent slot
    access(1, 12'h600, '1, 8'hFF, rd, er);
    access(1, 12'h640, 64'hF0, 8'hFF, rd, er);
    access(0, 12'h600, 0, 8'hFF, rd, er);
    chk("R6 read mask2", rd, '1);
    cpu_present[2] = 0;
    dev_lines = 64'h30;
    @(negedge clk);
    @(negedge clk);
    chk("R10 absent cpu2 silent", 64'(cpu_irq[2]), 0);
    chk("R4 irq3 on lines 4,5", 64'(cpu_irq[3]), 1);
    access(0, 12'h680, 0, 8'hFF, rd, er);
    chk("R3 view cpu2", rd, 64'h30);
    cpu_present[2] = 1;
    @(negedge clk);
    chk("R10 cpu2 restored", 64'(cpu_irq[2]), 1);

    // R7 writes to read-only offsets
    access(1, 12'h300, '1, 8'hFF, rd, er);
    chk("R7 raw write ok", 64'(er), 0);
    access(1, 12'h6C0, '0, 8'hFF, rd, er);
    chk("R7 view write ok", 64'(er), 0);
    access(0, 12'h300, 0, 8'hFF, rd, er);
    chk("R7 raw unchanged", rd, 64'h30);
    access(0, 12'h640, 0, 8'hFF, rd, er);
    chk("R7 mask3 unchanged", rd, 64'hF0);

    // R8 partial access
    access(1, 12'h640, 0, 8'h0F, rd, er);
    chk("R8 partial write error", 64'(er), 1);
    access(0, 12'h640, 0, 8'hFF, rd, er);
    chk("R8 mask3 unchanged", rd, 64'hF0);

    // R9 unlisted offsets
    access(0, 12'h208, 0, 8'hFF, rd, er);
    chk("R9 unlisted read error", 64'(er), 1);
    chk("R9 unlisted read data", rd, 0);
    access(1, 12'h100, '1, 8'hFF, rd, er);
    chk("R9 unlisted write error", 64'(er), 1);
    access(0, 12'h200, 0, 8'hFF, rd, er);
    chk("R9 mask0 unchanged", rd, 64'h8);

    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_addr = 12'h640;
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11 response held", rsp_rdata, 64'hF0);
      chk("R11 ready low while pending", 64'(req_ready), 0);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk("R11 response drained", 64'(rsp_valid), 0);

    // R4 mask write and line change on the same edge
    @(negedge clk);
    dev_lines = 64'h1;
    req_valid = 1; req_write = 1; req_addr = 12'h640; req_wdata = 64'h2;
    @(negedge clk);
    req_valid = 0;
    chk("R4 same-edge mask+line irq3", 64'(cpu_irq[3]), 0);
    chk("R4 same-edge irq2", 64'(cpu_irq[2]), 1);
    dev_lines = 64'h2;
    @(negedge clk);
    chk("R4 irq3 after line 1", 64'(cpu_irq[3]), 1);

    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule